// File: doc/BRIEF.md
# Vector Operand Swizzle and Destination Mask Stage

This block sits in front of a four-lane shader arithmetic unit. For each issued instruction it takes up to three source register indices, a choice of address register, an instruction form and an operand descriptor word. It fetches each source vector from one of its own register banks: inputs, temporaries or float constants. It adds a relative offset to one chosen source, rearranges each source's lanes, and can flip the sign of each source. It also decodes the destination index into a bank, a bank index and per-lane write enables. Prepared operands and destination controls appear one clock after the request and hold until the next request.

The arithmetic unit itself is not part of this block. Its results come back through a write port with a raw destination index and a lane mask. The block decodes that index again and writes only the enabled lanes of an output or temporary register. An index above both ranges drops the write. Input and constant registers are filled through a load port. Output registers can be read out through an observation port.

Top module: `vec_operand_stage`

## Requirements
- R1: Descriptor layout (31 bits): bits [3:0] are the destination lane mask, with bit i for lane i. Source s (s = 1, 2, 3) has its negate flag at bit 4+9*(s-1) and an 8-bit selector field just above it. Lane i of that field is bits [2i+1:2i]. Code k picks component k of the fetched vector, which is bits [24k+23:24k]. Lane i of the operand is placed at the same position i.
- R2: When a source's negate flag is set, bit 23 of each of its four result lanes is inverted and every other bit passes unchanged.
- R3: Operands and destination controls are registered. When rd_en is sampled high, op_valid is high in the next cycle. When rd_en is low, op_valid falls and op1, op2, op3 and the destination controls keep their values.
- R4: The address select code chooses the offset: 0 gives none, 1 gives areg0, 2 gives areg1, and 3 gives none. The offset index is (index + offset) mod 128.
- R5: The form code picks the offset target. Code 0 is the plain two-source form and offsets source 1. Code 1 is the swapped two-source form and offsets source 2. In both two-source forms, source 3 is fetched without an offset.
- R6: Form code 2 is the plain three-source form and offsets source 2. Form code 3 is the swapped three-source form and offsets source 3. Source 1 is never offset in either three-source form.
- R7: After the offset, source index 0x00-0x0F reads input register n, 0x10-0x1F reads temporary n-16, and 0x20-0x2F reads constant n-32. Any higher index reads a fixed vector with 24'h3F0000 in every lane.
- R8: The destination index is decoded at read time. Below 0x10 gives dst_file=1 (output) with dst_idx equal to the index. 0x10-0x1F gives dst_file=2 (temporary) with dst_idx equal to the index minus 16. In both cases dst_we equals the mask. Anything higher gives dst_file=0, dst_idx=0 and dst_we=0.
- R9: A result write with res_en changes only the lanes set in res_mask of output register res_dest (below 0x10) or of temporary res_dest-16 (0x10-0x1F). A write to any higher index changes no register.
- R10: Reset clears every register bank, op_valid, all operands and all destination controls to zero.
- R11: The load port writes all four lanes of input register ld_idx when ld_to_uni=0, or of constant register ld_idx when ld_to_uni=1. A load with ld_idx of 16 or more is ignored. obs_data shows output register obs_idx when obs_idx is below 16, and zero otherwise.
- R12: In a cycle that both reads and writes a register, the operand carries the value from before the write. The new value is seen by the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Load input or constant register |
| ld_to_uni | input | 1 | 1 selects the constant bank, 0 the input bank |
| ld_idx | input | 7 | Load register index |
| ld_data | input | 96 | Load vector, lane i in bits [24i+23:24i] |
| rd_en | input | 1 | Issue an operand request |
| rd_form | input | 2 | Instruction form code |
| rd_areg_sel | input | 2 | Address register select code |
| areg0 | input | 7 | Address register 0 |
| areg1 | input | 7 | Address register 1 |
| src1_idx | input | 7 | Source 1 index |
| src2_idx | input | 7 | Source 2 index |
| src3_idx | input | 7 | Source 3 index |
| rd_desc | input | 31 | Operand descriptor |
| rd_dest | input | 7 | Destination index of the request |
| op_valid | output | 1 | Operands valid this cycle |
| op1 | output | 96 | Prepared source 1 |
| op2 | output | 96 | Prepared source 2 |
| op3 | output | 96 | Prepared source 3 |
| dst_file | output | 2 | Destination bank: 0 none, 1 output, 2 temporary |
| dst_idx | output | 4 | Destination index within its bank |
| dst_we | output | 4 | Destination lane write enables |
| res_en | input | 1 | Result write strobe |
| res_dest | input | 7 | Raw destination index of the result |
| res_mask | input | 4 | Lane mask of the result |
| res_data | input | 96 | Result vector |
| obs_idx | input | 7 | Output register to observe |
| obs_data | output | 96 | Observed output register |

## Verification
The bench goes after the offset target in all four forms. A design that wires the offset to the wrong source reads a neighbouring register, and the mismatch shows on the operand. It also covers index wrap-around near 0x7F, the last and first entries of each source bank, and indices beyond the constants. A decoder that is off by one returns a real register where the fixed vector belongs. Negation is applied to lanes that already have the sign bit set, so a design that forces the sign instead of flipping it fails. Writes with partial masks, writes to out-of-range destinations and a write that collides with a read in the same cycle catch lane leakage, phantom writes and forwarding that should not happen.

// File: rtl/vos_pkg.sv
package vos_pkg;
   localparam int NUM_SRC = 3;

   typedef enum logic [1:0] {
      FORM_PAIR     = 2'd0,
      FORM_PAIR_INV = 2'd1,
      FORM_TRIO     = 2'd2,
      FORM_TRIO_INV = 2'd3
   } src_form_e;

   typedef enum logic [1:0] {
      DFILE_NONE = 2'd0,
      DFILE_OUT  = 2'd1,
      DFILE_TMP  = 2'd2
   } dst_file_e;

   typedef enum logic [1:0] {
      AREG_NONE = 2'd0,
      AREG_A0   = 2'd1,
      AREG_A1   = 2'd2,
      AREG_RSVD = 2'd3
   } areg_sel_e;
endpackage

// File: rtl/vos_regbank.sv
module vos_regbank #(
   parameter int FW    = 24,
   parameter int LANES = 4,
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH),
   localparam int VW   = FW * LANES
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [AW-1:0]    widx,
   input  logic [LANES-1:0] wlane,
   input  logic [VW-1:0]    wdata,
   output logic [VW-1:0]    q [DEPTH]
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int d = 0; d < DEPTH; d++) q[d] <= '0;
      end else if (we && (32'(widx) < DEPTH)) begin
         for (int l = 0; l < LANES; l++)
            if (wlane[l]) q[widx][l*FW +: FW] <= wdata[l*FW +: FW];
      end
   end
endmodule

// File: rtl/vos_swizzle.sv
module vos_swizzle #(
   parameter int FW    = 24,
   parameter int LANES = 4,
   localparam int SW   = $clog2(LANES),
   localparam int VW   = FW * LANES
) (
   input  logic [VW-1:0]       vec_i,
   input  logic [LANES*SW-1:0] sel_i,
   input  logic                neg_i,
   output logic [VW-1:0]       vec_o
);
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [FW-1:0] pick;
      assign pick = vec_i[32'(sel_i[l*SW +: SW])*FW +: FW];
      assign vec_o[l*FW +: FW] = {pick[FW-1] ^ neg_i, pick[FW-2:0]};
   end
endmodule

// File: rtl/vos_dest_decode.sv
module vos_dest_decode #(
   parameter int IDX_W = 7,
   parameter int REG_N = 16,
   parameter int LANES = 4,
   localparam int AW   = $clog2(REG_N)
) (
   input  logic [IDX_W-1:0] dest_i,
   input  logic [LANES-1:0] mask_i,
   output logic [1:0]       file_o,
   output logic [AW-1:0]    idx_o,
   output logic [LANES-1:0] we_o
);
   import vos_pkg::*;

   always_comb begin
      if (32'(dest_i) < REG_N) begin
         file_o = DFILE_OUT;
         idx_o  = AW'(dest_i);
         we_o   = mask_i;
      end else if (32'(dest_i) < 2 * REG_N) begin
         file_o = DFILE_TMP;
         idx_o  = AW'(dest_i - IDX_W'(REG_N));
         we_o   = mask_i;
      end else begin
         file_o = DFILE_NONE;
         idx_o  = '0;
         we_o   = '0;
      end
   end
endmodule

// File: rtl/vec_operand_stage.sv
module vec_operand_stage
   import vos_pkg::*;
#(
   parameter int             FW         = 24,
   parameter int             LANES      = 4,
   parameter int             IDX_W      = 7,
   parameter int             REG_N      = 16,
   parameter int             UNI_N      = 16,
   parameter logic [FW-1:0]  DUMMY_LANE = 24'h3F0000,
   localparam int            SW         = $clog2(LANES),
   localparam int            VW         = FW * LANES,
   localparam int            SRC_F      = 1 + LANES * SW,
   localparam int            DESC_W     = LANES + NUM_SRC * SRC_F,
   localparam int            RAW        = $clog2(REG_N),
   localparam int            UAW        = $clog2(UNI_N)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_en,
   input  logic              ld_to_uni,
   input  logic [IDX_W-1:0]  ld_idx,
   input  logic [VW-1:0]     ld_data,
   input  logic              rd_en,
   input  logic [1:0]        rd_form,
   input  logic [1:0]        rd_areg_sel,
   input  logic [IDX_W-1:0]  areg0,
   input  logic [IDX_W-1:0]  areg1,
   input  logic [IDX_W-1:0]  src1_idx,
   input  logic [IDX_W-1:0]  src2_idx,
   input  logic [IDX_W-1:0]  src3_idx,
   input  logic [DESC_W-1:0] rd_desc,
   input  logic [IDX_W-1:0]  rd_dest,
   output logic              op_valid,
   output logic [VW-1:0]     op1,
   output logic [VW-1:0]     op2,
   output logic [VW-1:0]     op3,
   output logic [1:0]        dst_file,
   output logic [RAW-1:0]    dst_idx,
   output logic [LANES-1:0]  dst_we,
   input  logic              res_en,
   input  logic [IDX_W-1:0]  res_dest,
   input  logic [LANES-1:0]  res_mask,
   input  logic [VW-1:0]     res_data,
   input  logic [IDX_W-1:0]  obs_idx,
   output logic [VW-1:0]     obs_data
);
   localparam logic [VW-1:0] DUMMY_VEC = {LANES{DUMMY_LANE}};

   if ((1 << SW) != LANES) begin : g_bad_lanes
      $error("LANES must be a power of two");
   end
   if (2 * REG_N + UNI_N > (1 << IDX_W)) begin : g_bad_map
      $error("register map does not fit the index width");
   end
   if (FW < 2) begin : g_bad_fw
      $error("FW too small for a sign bit");
   end

   // ---------------- register banks ----------------
   logic [VW-1:0] in_q  [REG_N];
   logic [VW-1:0] tmp_q [REG_N];
   logic [VW-1:0] out_q [REG_N];
   logic [VW-1:0] uni_q [UNI_N];

   logic [1:0]       wr_file;
   logic [RAW-1:0]   wr_idx;
   logic [LANES-1:0] wr_we;

   vos_dest_decode #(.IDX_W(IDX_W), .REG_N(REG_N), .LANES(LANES)) u_wr_dec (
      .dest_i(res_dest), .mask_i(res_mask),
      .file_o(wr_file), .idx_o(wr_idx), .we_o(wr_we)
   );

   vos_regbank #(.FW(FW), .LANES(LANES), .DEPTH(REG_N)) u_in_bank (
      .clk(clk), .rst_n(rst_n),
      .we(ld_en && !ld_to_uni && (32'(ld_idx) < REG_N)),
      .widx(ld_idx[RAW-1:0]), .wlane({LANES{1'b1}}), .wdata(ld_data), .q(in_q)
   );

   vos_regbank #(.FW(FW), .LANES(LANES), .DEPTH(UNI_N)) u_uni_bank (
      .clk(clk), .rst_n(rst_n),
      .we(ld_en && ld_to_uni && (32'(ld_idx) < UNI_N)),
      .widx(ld_idx[UAW-1:0]), .wlane({LANES{1'b1}}), .wdata(ld_data), .q(uni_q)
   );

   vos_regbank #(.FW(FW), .LANES(LANES), .DEPTH(REG_N)) u_tmp_bank (
      .clk(clk), .rst_n(rst_n),
      .we(res_en && (wr_file == DFILE_TMP)),
      .widx(wr_idx), .wlane(wr_we), .wdata(res_data), .q(tmp_q)
   );

   vos_regbank #(.FW(FW), .LANES(LANES), .DEPTH(REG_N)) u_out_bank (
      .clk(clk), .rst_n(rst_n),
      .we(res_en && (wr_file == DFILE_OUT)),
      .widx(wr_idx), .wlane(wr_we), .wdata(res_data), .q(out_q)
   );

   // ---------------- relative offset ----------------
   logic [IDX_W-1:0] off_val;
   always_comb begin
      case (areg_sel_e'(rd_areg_sel))
         AREG_A0: off_val = areg0;
         AREG_A1: off_val = areg1;
         default: off_val = '0;
      endcase
   end

   // ---------------- per-source fetch and swizzle ----------------
   logic [IDX_W-1:0] sidx [NUM_SRC];
   logic [VW-1:0]    swz  [NUM_SRC];
   logic [VW-1:0]    op_q [NUM_SRC];

   assign sidx[0] = src1_idx;
   assign sidx[1] = src2_idx;
   assign sidx[2] = src3_idx;

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      localparam int NEG_AT = LANES + s * SRC_F;
      localparam int SEL_AT = NEG_AT + 1;

      logic             off_here;
      logic [IDX_W-1:0] eff;
      logic [VW-1:0]    raw;

      always_comb begin
         case (src_form_e'(rd_form))
            FORM_PAIR:     off_here = (s == 0);
            FORM_PAIR_INV: off_here = (s == 1);
            FORM_TRIO:     off_here = (s == 1);
            default:       off_here = (s == 2);
         endcase
      end

      assign eff = sidx[s] + (off_here ? off_val : '0);

      always_comb begin
         if (32'(eff) < REG_N)
            raw = in_q[eff[RAW-1:0]];
         else if (32'(eff) < 2 * REG_N)
            raw = tmp_q[RAW'(eff - IDX_W'(REG_N))];
         else if (32'(eff) < 2 * REG_N + UNI_N)
            raw = uni_q[UAW'(eff - IDX_W'(2 * REG_N))];
         else
            raw = DUMMY_VEC;
      end

      vos_swizzle #(.FW(FW), .LANES(LANES)) u_swz (
         .vec_i(raw), .sel_i(rd_desc[SEL_AT +: LANES*SW]),
         .neg_i(rd_desc[NEG_AT]), .vec_o(swz[s])
      );
   end

   // ---------------- destination decode at issue ----------------
   logic [1:0]       rd_file;
   logic [RAW-1:0]   rd_idx;
   logic [LANES-1:0] rd_we;

   vos_dest_decode #(.IDX_W(IDX_W), .REG_N(REG_N), .LANES(LANES)) u_rd_dec (
      .dest_i(rd_dest), .mask_i(rd_desc[LANES-1:0]),
      .file_o(rd_file), .idx_o(rd_idx), .we_o(rd_we)
   );

   // ---------------- output stage ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_valid <= 1'b0;
         for (int s = 0; s < NUM_SRC; s++) op_q[s] <= '0;
         dst_file <= DFILE_NONE;
         dst_idx  <= '0;
         dst_we   <= '0;
      end else begin
         op_valid <= rd_en;
         if (rd_en) begin
            for (int s = 0; s < NUM_SRC; s++) op_q[s] <= swz[s];
            dst_file <= rd_file;
            dst_idx  <= rd_idx;
            dst_we   <= rd_we;
         end
      end
   end

   assign op1 = op_q[0];
   assign op2 = op_q[1];
   assign op3 = op_q[2];

   assign obs_data = (32'(obs_idx) < REG_N) ? out_q[obs_idx[RAW-1:0]] : '0;
endmodule

// File: rtl/vos_checker.sv
module vos_checker #(
   parameter int IDX_W = 7,
   parameter int REG_N = 16,
   parameter int LANES = 4,
   parameter int VW    = 96
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rd_en,
   input logic [IDX_W-1:0] rd_dest,
   input logic [LANES-1:0] rd_mask,
   input logic             res_en,
   input logic [IDX_W-1:0] res_dest,
   input logic [IDX_W-1:0] obs_idx,
   input logic [VW-1:0]    obs_data,
   input logic             op_valid,
   input logic [VW-1:0]    op1,
   input logic [VW-1:0]    op2,
   input logic [VW-1:0]    op3,
   input logic [1:0]       dst_file,
   input logic [LANES-1:0] dst_we
);
   p_issue_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> op_valid);

   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> (!op_valid && $stable(op1) && $stable(op2) && $stable(op3)));

   p_nodst_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (32'(rd_dest) >= 2 * REG_N)) |=> (dst_file == 2'd0 && dst_we == '0));

   p_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> ((dst_we & ~$past(rd_mask)) == '0));

   p_discard_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!res_en || (32'(res_dest) >= REG_N)) |=>
         ((obs_idx != $past(obs_idx)) || $stable(obs_data)));
endmodule

bind vec_operand_stage vos_checker #(
   .IDX_W(IDX_W), .REG_N(REG_N), .LANES(LANES), .VW(VW)
) u_vos_chk (
   .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_dest(rd_dest),
   .rd_mask(rd_desc[LANES-1:0]), .res_en(res_en), .res_dest(res_dest),
   .obs_idx(obs_idx), .obs_data(obs_data), .op_valid(op_valid),
   .op1(op1), .op2(op2), .op3(op3), .dst_file(dst_file), .dst_we(dst_we)
);

// File: tb/vec_operand_stage_bench.sv
module vec_operand_stage_bench;
   localparam int VW = 96;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ld_en = 1'b0, ld_to_uni = 1'b0;
   logic [6:0]  ld_idx = '0;
   logic [95:0] ld_data = '0;
   logic        rd_en = 1'b0;
   logic [1:0]  rd_form = '0, rd_areg_sel = '0;
   logic [6:0]  areg0 = '0, areg1 = '0, src1_idx = '0, src2_idx = '0, src3_idx = '0;
   logic [30:0] rd_desc = '0;
   logic [6:0]  rd_dest = '0;
   logic        op_valid;
   logic [95:0] op1, op2, op3;
   logic [1:0]  dst_file;
   logic [3:0]  dst_idx, dst_we;
   logic        res_en = 1'b0;
   logic [6:0]  res_dest = '0;
   logic [3:0]  res_mask = '0;
   logic [95:0] res_data = '0;
   logic [6:0]  obs_idx = '0;
   logic [95:0] obs_data;

   always #2 clk = ~clk;

   vec_operand_stage u_vec_operand_stage (
      .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_to_uni(ld_to_uni), .ld_idx(ld_idx),
      .ld_data(ld_data), .rd_en(rd_en), .rd_form(rd_form), .rd_areg_sel(rd_areg_sel),
      .areg0(areg0), .areg1(areg1), .src1_idx(src1_idx), .src2_idx(src2_idx),
      .src3_idx(src3_idx), .rd_desc(rd_desc), .rd_dest(rd_dest), .op_valid(op_valid),
      .op1(op1), .op2(op2), .op3(op3), .dst_file(dst_file), .dst_idx(dst_idx),
      .dst_we(dst_we), .res_en(res_en), .res_dest(res_dest), .res_mask(res_mask),
      .res_data(res_data), .obs_idx(obs_idx), .obs_data(obs_data)
   );

   // ---------------- reference model ----------------
   logic [95:0] m_in [16], m_tmp [16], m_out [16], m_uni [16];
   logic [95:0] m_op [3];
   logic        m_valid;
   logic [1:0]  m_file;
   logic [3:0]  m_didx, m_dwe;

   int    n_chk = 0, n_fail = 0;
   string tag = "R10";

   initial begin
      for (int i = 0; i < 16; i++) begin
         m_in[i] = '0; m_tmp[i] = '0; m_out[i] = '0; m_uni[i] = '0;
      end
      for (int s = 0; s < 3; s++) m_op[s] = '0;
      m_valid = 1'b0; m_file = '0; m_didx = '0; m_dwe = '0;
   end

   function automatic logic [95:0] mfetch(int idx);
      if (idx < 16)      return m_in[idx];
      else if (idx < 32) return m_tmp[idx-16];
      else if (idx < 48) return m_uni[idx-32];
      else               return {4{24'h3F0000}};
   endfunction

   function automatic logic [95:0] mswz(logic [95:0] v, logic [30:0] d, int s);
      logic [95:0] r;
      int base;
      base = 4 + 9*s;
      for (int l = 0; l < 4; l++) begin
         int k;
         logic [23:0] c;
         k = int'((d >> (base + 1 + 2*l)) & 31'd3);
         c = v[k*24 +: 24];
         if (d[base]) c[23] = ~c[23];
         r[l*24 +: 24] = c;
      end
      return r;
   endfunction

   task automatic model_update();
      if (rd_en) begin
         int tgt, off;
         int idx [3];
         tgt = (rd_form == 2'd0) ? 0 : (rd_form == 2'd3) ? 2 : 1;
         off = (rd_areg_sel == 2'd1) ? int'(areg0) : (rd_areg_sel == 2'd2) ? int'(areg1) : 0;
         idx[0] = int'(src1_idx); idx[1] = int'(src2_idx); idx[2] = int'(src3_idx);
         for (int s = 0; s < 3; s++) begin
            int e;
            e = (s == tgt) ? ((idx[s] + off) % 128) : idx[s];
            m_op[s] = mswz(mfetch(e), rd_desc, s);
         end
         if (rd_dest < 7'd16)      begin m_file = 2'd1; m_didx = rd_dest[3:0]; m_dwe = rd_desc[3:0]; end
         else if (rd_dest < 7'd32) begin m_file = 2'd2; m_didx = 4'(rd_dest - 7'd16); m_dwe = rd_desc[3:0]; end
         else                      begin m_file = 2'd0; m_didx = '0; m_dwe = '0; end
      end
      m_valid = rd_en;
      if (ld_en && ld_idx < 7'd16) begin
         if (ld_to_uni) m_uni[ld_idx[3:0]] = ld_data;
         else           m_in[ld_idx[3:0]]  = ld_data;
      end
      if (res_en) begin
         for (int l = 0; l < 4; l++) if (res_mask[l]) begin
            if (res_dest < 7'd16)      m_out[res_dest[3:0]][l*24 +: 24] = res_data[l*24 +: 24];
            else if (res_dest < 7'd32) m_tmp[4'(res_dest - 7'd16)][l*24 +: 24] = res_data[l*24 +: 24];
         end
      end
   endtask

   task automatic chk(string what, logic [95:0] act, logic [95:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic compare_all();
      chk("op_valid", 96'(op_valid), 96'(m_valid));
      chk("op1", op1, m_op[0]);
      chk("op2", op2, m_op[1]);
      chk("op3", op3, m_op[2]);
      chk("dst_file", 96'(dst_file), 96'(m_file));
      chk("dst_idx", 96'(dst_idx), 96'(m_didx));
      chk("dst_we", 96'(dst_we), 96'(m_dwe));
      chk("obs_data", obs_data, (obs_idx < 7'd16) ? m_out[obs_idx[3:0]] : 96'd0);
   endtask

   task automatic cycle();
      @(posedge clk);
      model_update();
      @(negedge clk);
      compare_all();
   endtask

   function automatic logic [30:0] mkdesc(logic [3:0] m, logic n1, logic [7:0] s1,
                                          logic n2, logic [7:0] s2, logic n3, logic [7:0] s3);
      return {s3, n3, s2, n2, s1, n1, m};
   endfunction

   function automatic logic [95:0] pat(int base, int idx);
      logic [95:0] v;
      for (int l = 0; l < 4; l++) v[l*24 +: 24] = 24'(base + idx*16 + l);
      return v;
   endfunction

   task automatic do_ld(logic uni, int idx, logic [95:0] d);
      ld_en = 1'b1; ld_to_uni = uni; ld_idx = 7'(idx); ld_data = d;
      cycle();
      ld_en = 1'b0;
   endtask

   task automatic do_wr(int dest, logic [3:0] m, logic [95:0] d);
      res_en = 1'b1; res_dest = 7'(dest); res_mask = m; res_data = d;
      cycle();
      res_en = 1'b0;
   endtask

   task automatic set_rd(logic [1:0] f, logic [1:0] as, int i1, int i2, int i3,
                         logic [30:0] d, int dest);
      rd_en = 1'b1; rd_form = f; rd_areg_sel = as;
      src1_idx = 7'(i1); src2_idx = 7'(i2); src3_idx = 7'(i3);
      rd_desc = d; rd_dest = 7'(dest);
   endtask

   task automatic do_rd(logic [1:0] f, logic [1:0] as, int i1, int i2, int i3,
                        logic [30:0] d, int dest);
      set_rd(f, as, i1, i2, i3, d, dest);
      cycle();
      rd_en = 1'b0;
   endtask

   localparam logic [7:0] ID = 8'hE4, REV = 8'h1B, BX = 8'h00, BW = 8'hFF, MIX = 8'h9C;

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   // ---------------- stimulus ----------------
   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      tag = "R10";                      // reset state
      compare_all();
      rst_n = 1'b1;
      cycle();

      tag = "R11";                      // load port, ignored high index, observe port
      for (int i = 0; i < 16; i++) do_ld(1'b0, i, pat(24'h010000, i));
      for (int i = 0; i < 16; i++) do_ld(1'b1, i, pat(24'h020000, i));
      do_ld(1'b0, 9, {24'h812345, 24'h000001, 24'h7FFFFF, 24'h800000});
      do_ld(1'b0, 20, {4{24'hABCDEF}});
      do_ld(1'b1, 100, {4{24'h123456}});
      do_rd(2'd0, 2'd0, 4, 32, 15, mkdesc(4'hF, 0, ID, 0, ID, 0, ID), 0);
      obs_idx = 7'd40; cycle(); obs_idx = 7'd0;

      tag = "R1";                       // lane selection patterns
      do_rd(2'd2, 2'd0, 1, 2, 3, mkdesc(4'h0, 0, REV, 0, BX, 0, BW), 64);
      do_rd(2'd2, 2'd0, 5, 33, 6, mkdesc(4'h0, 0, MIX, 0, ID, 0, REV), 64);

      tag = "R2";                       // sign flip on mixed-sign lanes
      do_rd(2'd2, 2'd0, 9, 9, 9, mkdesc(4'h0, 1, ID, 0, ID, 1, REV), 64);
      do_rd(2'd2, 2'd0, 9, 2, 9, mkdesc(4'h0, 0, BW, 1, BX, 1, MIX), 64);

      tag = "R9";                       // masked writes and discarded writes
      do_wr(16 + 3, 4'b0101, {4{24'h55AA55}});
      do_wr(2, 4'b1010, {24'h111111, 24'h222222, 24'h333333, 24'h444444});
      obs_idx = 7'd2; cycle();
      do_wr(64, 4'hF, {4{24'hDEAD00}});
      do_wr(32, 4'hF, {4{24'hDEAD01}});
      do_wr(2, 4'b0000, {4{24'hDEAD02}});
      do_rd(2'd0, 2'd0, 16 + 3, 16 + 0, 16 + 15, mkdesc(4'hF, 0, ID, 0, ID, 0, ID), 1);
      obs_idx = 7'd0;

      tag = "R8";                       // destination decoding at the range edges
      do_rd(2'd0, 2'd0, 0, 0, 0, mkdesc(4'b1011, 0, ID, 0, ID, 0, ID), 15);
      do_rd(2'd0, 2'd0, 0, 0, 0, mkdesc(4'b0110, 0, ID, 0, ID, 0, ID), 16);
      do_rd(2'd0, 2'd0, 0, 0, 0, mkdesc(4'b1111, 0, ID, 0, ID, 0, ID), 31);
      do_rd(2'd0, 2'd0, 0, 0, 0, mkdesc(4'b1111, 0, ID, 0, ID, 0, ID), 32);
      do_rd(2'd0, 2'd0, 0, 0, 0, mkdesc(4'b1001, 0, ID, 0, ID, 0, ID), 127);

      tag = "R4";                       // offset selection and wrap
      areg0 = 7'd3; areg1 = 7'd35;
      for (int as = 0; as < 4; as++)
         do_rd(2'd0, 2'(as), 1, 1, 1, mkdesc(4'hF, 0, ID, 0, ID, 0, ID), 0);
      areg0 = 7'h7E;
      do_rd(2'd0, 2'd1, 5, 5, 5, mkdesc(4'hF, 0, ID, 0, ID, 0, ID), 0);
      do_rd(2'd0, 2'd1, 1, 1, 1, mkdesc(4'hF, 0, ID, 0, ID, 0, ID), 0);

      tag = "R5";                       // two-source forms
      areg0 = 7'd2; areg1 = 7'd17;
      do_rd(2'd0, 2'd1, 1, 4, 6, mkdesc(4'hF, 0, ID, 0, ID, 0, ID), 0);
      do_rd(2'd1, 2'd1, 1, 4, 6, mkdesc(4'hF, 0, ID, 0, ID, 0, ID), 0);
      do_rd(2'd1, 2'd2, 1, 4, 6, mkdesc(4'hF, 0, ID, 0, ID, 0, ID), 0);

      tag = "R6";                       // three-source forms
      do_rd(2'd2, 2'd1, 1, 4, 6, mkdesc(4'hF, 0, ID, 0, ID, 0, ID), 0);
      do_rd(2'd3, 2'd1, 1, 4, 6, mkdesc(4'hF, 0, ID, 0, ID, 0, ID), 0);
      do_rd(2'd3, 2'd2, 7, 8, 10, mkdesc(4'hF, 0, ID, 0, ID, 0, ID), 0);

      tag = "R7";                       // source range edges and fixed vector
      do_rd(2'd0, 2'd0, 15, 16, 31, mkdesc(4'hF, 0, ID, 0, ID, 0, ID), 0);
      do_rd(2'd0, 2'd0, 32, 47, 48, mkdesc(4'hF, 0, ID, 0, ID, 0, ID), 0);
      do_rd(2'd0, 2'd0, 127, 64, 47, mkdesc(4'hF, 1, REV, 0, ID, 0, ID), 0);

      tag = "R12";                      // read and write of one register in one cycle
      set_rd(2'd0, 2'd0, 16 + 4, 16 + 4, 0, mkdesc(4'hF, 0, ID, 0, ID, 0, ID), 0);
      res_en = 1'b1; res_dest = 7'd20; res_mask = 4'hF; res_data = {4{24'h0C0FFE}};
      cycle();
      res_en = 1'b0; rd_en = 1'b0;
      do_rd(2'd0, 2'd0, 16 + 4, 0, 0, mkdesc(4'hF, 0, ID, 0, ID, 0, ID), 0);

      tag = "R3";                       // hold while idle
      repeat (3) cycle();

      tag = "R5";                       // mixed traffic
      for (int n = 0; n < 400; n++) begin
         rd_en = 1'($urandom); rd_form = 2'($urandom); rd_areg_sel = 2'($urandom);
         areg0 = 7'($urandom); areg1 = 7'($urandom);
         src1_idx = 7'($urandom % 64); src2_idx = 7'($urandom % 64); src3_idx = 7'($urandom);
         rd_desc = 31'($urandom); rd_dest = 7'($urandom % 48);
         ld_en = 1'($urandom); ld_to_uni = 1'($urandom); ld_idx = 7'($urandom % 24);
         ld_data = {$urandom, $urandom, $urandom};
         res_en = 1'($urandom); res_dest = 7'($urandom % 40); res_mask = 4'($urandom);
         res_data = {$urandom, $urandom, $urandom};
         obs_idx = 7'($urandom % 20);
         cycle();
      end
      rd_en = 1'b0; ld_en = 1'b0; res_en = 1'b0;
      cycle();

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule